// File: doc/BRIEF.md
# I2C Master Clock and Phase Timer

This block times the SCL waveform and the points where SDA may change for an I2C master. A byte-level controller asks for one bus phase at a time: start, repeated start, one data bit, or stop. The block drives both lines through open-drain drive-low enables and raises a one-cycle completion pulse when the phase has finished. Every interval is a count of prescaled ticks. The tick rate is the block clock divided by two to the power of (exponent + 1). Four counts set the durations: a low count, a high count, a shared start/stop count and a data setup/hold count.

SCL low time within a phase has three parts: a data hold segment, then the low segment, then a data setup segment. SDA is updated between the first and second parts. The block samples both lines through synchronizers. Every wait that follows a release or a drive starts only when the new level is seen on the sensed line. A slave that holds SCL low therefore lengthens the low time but never shortens the high time. After a stop, the bus is reported idle only once both lines have read high for the start/stop count.

Top module: `i2c_phase_timer`

## Requirements
- R1: One tick lasts 2^(cfg_exp+1) clock cycles, and a segment of N ticks lasts exactly N times that number of cycles. A start holds SDA low for cfg_stasto ticks before it drives SCL low.
- R2: A bit, repeated start or stop accepted in the held-low state drives SCL low for (2*cfg_data + cfg_low) ticks, counted from the accept edge to the release. For a bit, sda_oe equals the inverse of cmd_bit when SCL is released.
- R3: The high time of a bit is counted from the cycle the sensed SCL reads high. The SCL line stays high for 3 + cfg_high*2^(cfg_exp+1) cycles, whether or not a slave stretched the clock before it.
- R4: While SCL is released but still reads low, the block neither drives SCL nor signals done.
- R5: A start (cmd_op 0) from the bus-idle state drives SDA low at once and drives SCL low after cfg_stasto ticks.
- R6: A repeated start (cmd_op 1) releases SDA during the low time. Once SCL is sensed high it waits cfg_stasto ticks and drives SDA low. After another cfg_stasto ticks it drives SCL low.
- R7: A stop (cmd_op 3) holds SDA low through the low time. Once SCL is sensed high it waits cfg_stasto ticks, then releases SDA and pulses done in the same cycle.
- R8: Reset leaves both enables off, with done, bus_idle and cmd_ready low. bus_idle rises only after both lines have been sensed high for cfg_stasto ticks, starting after reset or after the SDA release of a stop. A dip on either line restarts that count.
- R9: For a bit (cmd_op 2), rd_bit takes the sensed SDA level in the cycle that SCL is first sensed high, and keeps it until the next bit.
- R10: done is a single-cycle pulse. For start, bit and repeated start it comes 3 cycles after the edge that drives SCL low.
- R11: cmd_ready is high only in the bus-idle and held-low states. In bus-idle, any operation other than start is ignored. In held-low, a start is ignored. An ignored command gives no done and changes no line.
- R12: A count field of zero behaves exactly as a value of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_low | input | CNT_W | Middle low-segment length in ticks |
| cfg_high | input | CNT_W | SCL high length of a bit in ticks |
| cfg_stasto | input | CNT_W | Start/stop setup, hold and bus-free length in ticks |
| cfg_data | input | CNT_W | Data hold and data setup length in ticks |
| cfg_exp | input | EXP_W | Tick prescaler exponent |
| cmd_valid | input | 1 | Phase request |
| cmd_op | input | 2 | 0 start, 1 repeated start, 2 bit, 3 stop |
| cmd_bit | input | 1 | Data value for a bit (1 releases SDA) |
| cmd_ready | output | 1 | Block can take a phase request |
| done | output | 1 | One-cycle phase completion pulse |
| rd_bit | output | 1 | SDA level sampled at the last bit's rising SCL |
| bus_idle | output | 1 | Bus free time has elapsed with both lines high |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |

## Verification
The end of a slave's clock stretch and the sampling of the read bit can fall in the same cycle. Both lines pass through synchronizers of equal depth, so an SDA change made together with the SCL release reaches the block in the same cycle as the rising SCL it is sampled on. The bench provokes this by letting go of the held SCL and changing the slave's SDA at the same instant. It then requires rd_bit to carry the new level. It also requires the line-high time to match the unstretched value exactly, which shows the high count began at detection and not at release.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    // Phase request encoding seen on cmd_op
    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_RSTART = 2'd1,
        OP_BIT    = 2'd2,
        OP_STOP   = 2'd3
    } op_e;

    // Sequencer states
    typedef enum logic [3:0] {
        PH_FREE,      // bus free count, both lines must read high
        PH_IDLE,      // bus idle, waiting for a start
        PH_HELD,      // SCL held low between phases
        PH_ST_HD,     // start hold: SDA low, SCL high
        PH_LO_HOLD,   // data hold segment of the low time
        PH_LO_MID,    // middle low segment
        PH_LO_SETUP,  // data setup segment of the low time
        PH_WAIT_HI,   // SCL released, waiting to sense high
        PH_HI_BIT,    // high time of a data bit
        PH_RS_SU,     // repeated start setup
        PH_RS_HD,     // repeated start hold
        PH_PS_SU,     // stop setup
        PH_WAIT_LO    // SCL driven, waiting to sense low
    } phase_e;

endpackage

// File: rtl/bpg_sync.sv
module bpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    // Lines idle high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/bpg_prescaler.sv
module bpg_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic             restart,
    output logic             tick
);
    localparam int PCW = (1 << EXP_W) + 1;

    logic [PCW-1:0] pcnt_d, pcnt_q;
    logic [PCW-1:0] last_val;

    always_comb begin
        last_val = (PCW'(1) << ({1'b0, cfg_exp} + (EXP_W + 1)'(1))) - PCW'(1);
        tick     = (pcnt_q == last_val);
        pcnt_d   = (restart || tick) ? '0 : pcnt_q + PCW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // The shortest tick period is two cycles
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("a_r1_tick_gap: ticks in adjacent cycles");
endmodule

// File: rtl/bpg_phase_fsm.sv
module bpg_phase_fsm
    import bpg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_stasto,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bit,
    output logic             restart,
    output logic             cmd_ready,
    output logic             done,
    output logic             rd_bit,
    output logic             bus_idle,
    output logic             scl_oe,
    output logic             sda_oe
);
    typedef struct packed {
        phase_e           st;
        op_e              op;
        logic             bit_v;
        logic [CNT_W-1:0] cnt;
        logic             scl_oe;
        logic             sda_oe;
        logic             done;
        logic             rd;
        logic             bus_idle;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st:       PH_FREE,
        op:       OP_START,
        bit_v:    1'b0,
        cnt:      '0,
        scl_oe:   1'b0,
        sda_oe:   1'b0,
        done:     1'b0,
        rd:       1'b0,
        bus_idle: 1'b0
    };

    fsm_t             r_d, r_q;
    op_e              op_in;
    logic [CNT_W-1:0] seg_len;
    logic [CNT_W-1:0] seg_ticks;
    logic             seg_end;
    logic             free_rst;

    assign op_in = op_e'(cmd_op);

    // Segment length for the current state
    always_comb begin
        case (r_q.st)
            PH_FREE, PH_ST_HD, PH_RS_SU,
            PH_RS_HD, PH_PS_SU:        seg_len = cfg_stasto;
            PH_LO_HOLD, PH_LO_SETUP:   seg_len = cfg_data;
            PH_LO_MID:                 seg_len = cfg_low;
            PH_HI_BIT:                 seg_len = cfg_high;
            default:                   seg_len = '0;
        endcase
        seg_ticks = (seg_len == '0) ? CNT_W'(1) : seg_len;
        seg_end   = tick && (r_q.cnt == seg_ticks - CNT_W'(1));
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        free_rst = 1'b0;
        if (tick) r_d.cnt = r_q.cnt + CNT_W'(1);

        case (r_q.st)
            PH_FREE: begin
                if (!(scl_s && sda_s)) begin
                    free_rst = 1'b1;
                end else if (seg_end) begin
                    r_d.st       = PH_IDLE;
                    r_d.bus_idle = 1'b1;
                end
            end
            PH_IDLE: begin
                if (cmd_valid && op_in == OP_START) begin
                    r_d.st       = PH_ST_HD;
                    r_d.sda_oe   = 1'b1;
                    r_d.bus_idle = 1'b0;
                end
            end
            PH_HELD: begin
                if (cmd_valid && op_in != OP_START) begin
                    r_d.st    = PH_LO_HOLD;
                    r_d.op    = op_in;
                    r_d.bit_v = cmd_bit;
                end
            end
            PH_ST_HD: begin
                if (seg_end) begin
                    r_d.scl_oe = 1'b1;
                    r_d.st     = PH_WAIT_LO;
                end
            end
            PH_WAIT_LO: begin
                if (!scl_s) begin
                    r_d.st   = PH_HELD;
                    r_d.done = 1'b1;
                end
            end
            PH_LO_HOLD: begin
                if (seg_end) begin
                    r_d.st = PH_LO_MID;
                    case (r_q.op)
                        OP_BIT:  r_d.sda_oe = !r_q.bit_v;
                        OP_STOP: r_d.sda_oe = 1'b1;
                        default: r_d.sda_oe = 1'b0;
                    endcase
                end
            end
            PH_LO_MID: begin
                if (seg_end) r_d.st = PH_LO_SETUP;
            end
            PH_LO_SETUP: begin
                if (seg_end) begin
                    r_d.scl_oe = 1'b0;
                    r_d.st     = PH_WAIT_HI;
                end
            end
            PH_WAIT_HI: begin
                if (scl_s) begin
                    case (r_q.op)
                        OP_BIT: begin
                            r_d.rd = sda_s;
                            r_d.st = PH_HI_BIT;
                        end
                        OP_RSTART: r_d.st = PH_RS_SU;
                        default:   r_d.st = PH_PS_SU;
                    endcase
                end
            end
            PH_HI_BIT: begin
                if (seg_end) begin
                    r_d.scl_oe = 1'b1;
                    r_d.st     = PH_WAIT_LO;
                end
            end
            PH_RS_SU: begin
                if (seg_end) begin
                    r_d.sda_oe = 1'b1;
                    r_d.st     = PH_RS_HD;
                end
            end
            PH_RS_HD: begin
                if (seg_end) begin
                    r_d.scl_oe = 1'b1;
                    r_d.st     = PH_WAIT_LO;
                end
            end
            PH_PS_SU: begin
                if (seg_end) begin
                    r_d.sda_oe = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.st     = PH_FREE;
                end
            end
            default: r_d.st = PH_FREE;
        endcase

        // Every segment begins with fresh tick and segment counts
        restart = (r_d.st != r_q.st) || free_rst;
        if (restart) r_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= FSM_RST;
        else        r_q <= r_d;
    end

    assign cmd_ready = (r_q.st == PH_IDLE) || (r_q.st == PH_HELD);
    assign done      = r_q.done;
    assign rd_bit    = r_q.rd;
    assign bus_idle  = r_q.bus_idle;
    assign scl_oe    = r_q.scl_oe;
    assign sda_oe    = r_q.sda_oe;

    // R2: SCL stays driven while the low segments run
    a_r2_scl_low_in_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st inside {PH_LO_HOLD, PH_LO_MID, PH_LO_SETUP}) |-> r_q.scl_oe)
        else $error("a_r2_scl_low_in_low_time");

    // R4: a stretched clock holds the block
    a_r4_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PH_WAIT_HI && !scl_s) |=> (!r_q.scl_oe && !r_q.done))
        else $error("a_r4_stretch_holds");

    // R10: done never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done)
        else $error("a_r10_done_single");

    // R11: only a start leaves the bus-idle state
    a_r11_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PH_IDLE && !(cmd_valid && op_in == OP_START)) |=> (r_q.st == PH_IDLE))
        else $error("a_r11_idle_ignores");

    // R8: bus idle only follows both lines sensed high
    a_r8_idle_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.bus_idle) |-> $past(scl_s && sda_s))
        else $error("a_r8_idle_after_high");
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int CNT_W       = 8,
    parameter int EXP_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_stasto,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bit,
    output logic             cmd_ready,
    output logic             done,
    output logic             rd_bit,
    output logic             bus_idle,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam int N_LINES = 2;
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_sync;
    logic               tick;
    logic               restart;

    assign line_raw[SCL_IDX] = scl_i;
    assign line_raw[SDA_IDX] = sda_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        bpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_sync[g])
        );
    end

    bpg_prescaler #(.EXP_W(EXP_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_exp(cfg_exp),
        .restart(restart),
        .tick   (tick)
    );

    bpg_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .scl_s     (line_sync[SCL_IDX]),
        .sda_s     (line_sync[SDA_IDX]),
        .cfg_low   (cfg_low),
        .cfg_high  (cfg_high),
        .cfg_stasto(cfg_stasto),
        .cfg_data  (cfg_data),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .restart   (restart),
        .cmd_ready (cmd_ready),
        .done      (done),
        .rd_bit    (rd_bit),
        .bus_idle  (bus_idle),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );
endmodule

// File: tb/test_i2c_phase_timer.sv
module test_i2c_phase_timer;
    localparam int CNT_W = 8;
    localparam int EXP_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_low = '0, cfg_high = '0, cfg_stasto = '0, cfg_data = '0;
    logic [EXP_W-1:0] cfg_exp = '0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic             cmd_bit = 1'b0;
    logic             cmd_ready, done, rd_bit, bus_idle;
    logic             scl_i, sda_i, scl_oe, sda_oe;
    logic             scl_pull = 1'b0, sda_pull = 1'b0;

    int checks = 0;
    int errors = 0;
    int e_div, e_h, e_l, e_d, e_s;

    always #4 clk = ~clk;

    assign scl_i = !(scl_oe || scl_pull);
    assign sda_i = !(sda_oe || sda_pull);

    i2c_phase_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) i_i2c_phase_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_stasto(cfg_stasto),
        .cfg_data(cfg_data), .cfg_exp(cfg_exp),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
        .cmd_ready(cmd_ready), .done(done), .rd_bit(rd_bit), .bus_idle(bus_idle),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Zero count means one tick (R12)
    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic set_cfg(input int e, input int h, input int l, input int d, input int s);
        cfg_exp    = EXP_W'(e);
        cfg_high   = CNT_W'(h);
        cfg_low    = CNT_W'(l);
        cfg_data   = CNT_W'(d);
        cfg_stasto = CNT_W'(s);
        e_div = 1 << (e + 1);
        e_h = eff(h); e_l = eff(l); e_d = eff(d); e_s = eff(s);
    endtask

    task automatic issue(input int op, input bit b);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_bit   = b;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Accept edge to SCL release, checked against the low-time sum
    task automatic low_time(input string tag);
        int n = 0;
        while (scl_oe) begin n++; @(negedge clk); end
        chk(n == (2 * e_d + e_l) * e_div, tag, n, (2 * e_d + e_l) * e_div);
    endtask

    task automatic do_start();
        int n = 0;
        int c = 0;
        issue(0, 1'b0);
        while (!scl_oe) begin n++; @(negedge clk); end
        chk(n == e_s * e_div, "R1 R5 start hold", n, e_s * e_div);
        chk(sda_oe == 1'b1, "R5 sda low at start", int'(sda_oe), 1);
        while (!done) begin c++; @(negedge clk); end
        chk(c == 3, "R10 start done delay", c, 3);
    endtask

    task automatic do_bit(input bit b, input bit sb, input bit sa, input int stretch);
        int h = 0;
        int c = 0;
        sda_pull = sb;
        scl_pull = (stretch > 0);
        issue(2, b);
        low_time("R2 bit low time");
        chk(sda_oe == !b, "R2 data at release", int'(sda_oe), int'(!b));
        for (int i = 0; i < stretch; i++) begin
            chk(!scl_oe && !done, "R4 stretch hold", int'(scl_oe || done), 0);
            @(negedge clk);
        end
        if (stretch > 0) sda_pull = sa;
        scl_pull = 1'b0;
        while (!(scl_oe || scl_pull)) begin h++; @(negedge clk); end
        chk(h == 3 + e_h * e_div, "R3 high time", h, 3 + e_h * e_div);
        while (!done) begin c++; @(negedge clk); end
        chk(c == 3, "R10 bit done delay", c, 3);
        chk(rd_bit == (b && !(stretch > 0 ? sa : sb)), "R9 read bit",
            int'(rd_bit), int'(b && !(stretch > 0 ? sa : sb)));
        sda_pull = 1'b0;
    endtask

    task automatic do_rstart();
        int r = 0;
        int q = 0;
        issue(1, 1'b0);
        low_time("R2 rstart low time");
        chk(sda_oe == 1'b0, "R6 sda released", int'(sda_oe), 0);
        while (!sda_oe) begin r++; @(negedge clk); end
        chk(r == 3 + e_s * e_div, "R6 rstart setup", r, 3 + e_s * e_div);
        while (!scl_oe) begin q++; @(negedge clk); end
        chk(q == e_s * e_div, "R6 rstart hold", q, e_s * e_div);
        wait_done();
    endtask

    task automatic do_stop();
        int r = 0;
        int f = 0;
        issue(3, 1'b0);
        low_time("R2 stop low time");
        chk(sda_oe && !cmd_ready, "R7 sda held low", int'(sda_oe), 1);
        while (sda_oe) begin r++; @(negedge clk); end
        chk(r == 3 + e_s * e_div, "R7 stop setup", r, 3 + e_s * e_div);
        chk(done == 1'b1, "R7 done with sda release", int'(done), 1);
        while (!bus_idle) begin f++; @(negedge clk); end
        chk(f == 2 + e_s * e_div, "R8 bus free time", f, 2 + e_s * e_div);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        set_cfg(0, 1, 1, 1, 2);
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe && !done && !bus_idle && !cmd_ready, "R8 reset state",
            int'({scl_oe, sda_oe, done, bus_idle, cmd_ready}), 0);
        rst_n = 1'b1;
        n = 0;
        while (!bus_idle) begin n++; @(negedge clk); end
        chk(n == e_s * e_div, "R8 idle after reset", n, e_s * e_div);
        chk(cmd_ready == 1'b1, "R11 ready when idle", int'(cmd_ready), 1);

        // R11: a bit request on an idle bus is dropped
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_bit = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!done && !scl_oe && !sda_oe && bus_idle, "R11 idle ignores bit",
                int'({done, scl_oe, sda_oe, bus_idle}), 1);
        end
        cmd_valid = 1'b0;

        do_start();
        // R11: a start while SCL is held low is dropped
        cmd_valid = 1'b1; cmd_op = 2'd0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!done && scl_oe && sda_oe && cmd_ready, "R11 held ignores start",
                int'({done, scl_oe, sda_oe, cmd_ready}), 7);
        end
        cmd_valid = 1'b0;
        do_bit(1'b1, 1'b0, 1'b0, 0);
        do_bit(1'b1, 1'b0, 1'b1, 5);   // R4 R9: stretch ends as SDA falls
        do_stop();

        // R12 and R1: zero fields under a larger prescaler
        set_cfg(2, 0, 0, 0, 0);
        do_start();
        do_bit(1'b0, 1'b0, 1'b0, 0);
        do_rstart();
        do_bit(1'b1, 1'b1, 1'b1, 0);
        do_stop();

        // Sweep of small configurations
        for (int e = 0; e < 2; e++)
            for (int h = 0; h < 3; h++)
                for (int l = 0; l < 3; l++)
                    for (int d = 0; d < 2; d++)
                        for (int s = 0; s < 3; s += 2) begin
                            set_cfg(e, h, l, d, s);
                            do_start();
                            do_bit(1'b1, 1'b0, 1'b0, 0);
                            do_bit(1'b1, 1'b1, 1'b1, 0);
                            do_bit(1'b0, 1'b0, 1'b0, 0);
                            do_rstart();
                            do_bit(1'b1, 1'b1, 1'b0, 2);
                            do_stop();
                        end
        summary();
    end
endmodule